// File: doc/BRIEF.md
# Fractional Clock-Enable Divider with Suspend Handshake

This block turns a fast input clock into a stream of single-cycle enable pulses. A downstream module uses the pulses to qualify its own clocked logic. A 2-bit mode field selects how the pulses are spaced.

- **Integer mode:** a counter climbs to all ones and then reloads from a step value, so the pulses are evenly spaced.
- **Fractional mode:** the step is added into an accumulator each cycle, and a pulse appears whenever the addition overflows. The average rate is then step / 2^W of the input clock.
- **Stopped:** the other two mode codes stop the pulse stream.

Several register-style inputs control the block:

- A disable bit stops everything. The only thing that still acts while it is set is a write to the mode field.
- An external enable pin clears the disable bit, but only when a hardware-control select bit permits it.
- A suspend request is answered by an acknowledge. Once both are set, the divider freezes.

The running count or sum is brought out as a status value.

Top module: `frac_clk_div`

## Requirements
- R1: While reset is asserted, `result_o` is 0 and `clk_en_o`, `dis_o` and `susp_ack_o` are 0.
- R2: A cycle with `mode_wr_i`=1 and `mode_i` equal to 2'b01 or 2'b10 loads `result_o` with all ones (0x3FF at the default width) at the next edge. This holds whatever the disable and suspend state. A write of 2'b00 or 2'b11 leaves `result_o` unchanged.
- R3: In integer mode (code 2'b01) while advancing, `result_o` increments by one each clock. In the clock after it holds 0x3FF it reloads from `step_i`, and `clk_en_o` is 1 in that same cycle. The pulse period is therefore 0x400 minus the step.
- R4: In fractional mode (code 2'b10) while advancing, `result_o` becomes (result + step) mod 2^W each clock. `clk_en_o` is 1 in the cycle after an addition that carried out of the top bit.
- R5: With mode code 2'b00 or 2'b11, `result_o` holds and `clk_en_o` stays 0.
- R6: While `dis_o` is 1, `result_o` is frozen except for the preset of R2, and `clk_en_o` is 0 in the following cycle.
- R7: When `hw_en_i` and `ext_en_i` are both 1, `dis_o` is 0 at the next edge. This clear takes priority over a software write of 1.
- R8: When `hw_en_i` is 0, `ext_en_i` has no effect: `dis_o` changes only through `dis_wr_i`/`dis_val_i`.
- R9: `susp_ack_o` rises one clock after `susp_req_i` is seen while the divider is running, meaning not disabled and in mode 01 or 10. It stays 0 if the request arrives while the divider is stopped. It falls one clock after the request is removed.
- R10: While `susp_req_i` and `susp_ack_o` are both 1, `result_o` is frozen and no `clk_en_o` pulse is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_wr_i | input | 1 | Write strobe for the mode field |
| mode_i | input | 2 | Mode value: 01 integer, 10 fractional, 00/11 stopped |
| step_i | input | RES_W | Step value (reload value or addend) |
| dis_wr_i | input | 1 | Write strobe for the disable bit |
| dis_val_i | input | 1 | Value written to the disable bit |
| hw_en_i | input | 1 | Allows the external pin to clear the disable bit |
| ext_en_i | input | 1 | External clock-enable pin |
| susp_req_i | input | 1 | Suspend request |
| clk_en_o | output | 1 | Single-cycle enable pulse |
| result_o | output | RES_W | Counter or accumulator status |
| dis_o | output | 1 | Disable bit readback |
| susp_ack_o | output | 1 | Suspend acknowledge |

## Verification
The bench watches the cycle where the counter sits at all ones. A design off by one there would give a period of 0x3FF or 0x401 minus the step instead of 0x400 minus it. It drives fractional steps of 0x100 and 0x3FF to catch a carry taken from the wrong bit or dropped. It writes the mode field while disabled and while suspended, where a design that gated the preset would keep the stale count. It raises the external pin with hardware control on and off and against a software write of 1. It also requests suspend while stopped, where a loose handshake would acknowledge with nothing running.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
   typedef enum logic [1:0] {
      FD_STOP = 2'b00,
      FD_NORM = 2'b01,
      FD_FRAC = 2'b10,
      FD_HALT = 2'b11
   } fd_mode_e;
endpackage

// File: rtl/fdiv_ctrl.sv
module fdiv_ctrl
   import fdiv_pkg::*;
(
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     mode_wr_i,
   input  logic [1:0] mode_i,
   input  logic     dis_wr_i,
   input  logic     dis_val_i,
   input  logic     hw_en_i,
   input  logic     ext_en_i,
   input  logic     susp_req_i,
   output fd_mode_e mode_o,
   output logic     advance_o,
   output logic     load_o,
   output logic     dis_o,
   output logic     ack_o
);
   fd_mode_e mode_q;
   logic     dis_q;
   logic     ack_q;
   logic     running;
   logic     frozen;

   assign running   = !dis_q && ((mode_q == FD_NORM) || (mode_q == FD_FRAC));
   assign frozen    = susp_req_i && ack_q;
   assign advance_o = running && !frozen && !mode_wr_i;
   assign load_o    = mode_wr_i &&
                      ((fd_mode_e'(mode_i) == FD_NORM) || (fd_mode_e'(mode_i) == FD_FRAC));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         mode_q <= FD_STOP;
         dis_q  <= 1'b0;
         ack_q  <= 1'b0;
      end else begin
         if (mode_wr_i) mode_q <= fd_mode_e'(mode_i);
         // R7: pin clear wins over a software write; R8: pin ignored otherwise
         if (hw_en_i && ext_en_i) dis_q <= 1'b0;
         else if (dis_wr_i)       dis_q <= dis_val_i;
         // R9: acknowledge only while running, hold while requested
         ack_q <= susp_req_i && (ack_q || running);
      end
   end

   assign mode_o = mode_q;
   assign dis_o  = dis_q;
   assign ack_o  = ack_q;

   a_r7_hw_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hw_en_i && ext_en_i) |=> !dis_q);
   a_r8_pin_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!hw_en_i && !dis_wr_i) |=> $stable(dis_q));
   a_r9_ack_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !susp_req_i |=> !ack_q);
   a_r9_ack_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (susp_req_i && running) |=> ack_q);
endmodule

// File: rtl/fdiv_core.sv
module fdiv_core
   import fdiv_pkg::*;
#(
   parameter int unsigned RES_W   = 10,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  fd_mode_e         mode_i,
   input  logic             advance_i,
   input  logic             load_i,
   input  logic [RES_W-1:0] step_i,
   output logic [RES_W-1:0] result_o,
   output logic             en_o
);
   localparam logic [RES_W-1:0] ALL_ONES = {RES_W{1'b1}};
   localparam logic [RES_W-1:0] ONE      = RES_W'(1);

   logic [RES_W-1:0] result_q;
   logic [RES_W-1:0] result_d;
   logic [RES_W:0]   sum;
   logic             hit;

   assign sum = {1'b0, result_q} + {1'b0, step_i};

   always_comb begin
      result_d = result_q;
      hit      = 1'b0;
      if (advance_i) begin
         case (mode_i)
            FD_NORM: begin
               if (result_q == ALL_ONES) begin
                  hit      = 1'b1;
                  result_d = step_i;
               end else begin
                  result_d = result_q + ONE;
               end
            end
            FD_FRAC: begin
               hit      = sum[RES_W];
               result_d = sum[RES_W-1:0];
            end
            default: ;
         endcase
      end
      if (load_i) result_d = ALL_ONES;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) result_q <= '0;
      else         result_q <= result_d;
   end

   generate
      if (REG_OUT) begin : g_reg_out
         logic en_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) en_q <= 1'b0;
            else         en_q <= hit;
         end
         assign en_o = en_q;
      end else begin : g_comb_out
         assign en_o = hit;
      end
   endgenerate

   assign result_o = result_q;

   a_r2_preset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      load_i |=> (result_q == ALL_ONES));
   a_r5_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!advance_i && !load_i) |=> $stable(result_q));
   a_r3_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (advance_i && !load_i && mode_i == FD_NORM && result_q == ALL_ONES)
      |=> (result_q == $past(step_i)));
endmodule

// File: rtl/frac_clk_div.sv
module frac_clk_div
   import fdiv_pkg::*;
#(
   parameter int unsigned RES_W   = 10,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             mode_wr_i,
   input  logic [1:0]       mode_i,
   input  logic [RES_W-1:0] step_i,
   input  logic             dis_wr_i,
   input  logic             dis_val_i,
   input  logic             hw_en_i,
   input  logic             ext_en_i,
   input  logic             susp_req_i,
   output logic             clk_en_o,
   output logic [RES_W-1:0] result_o,
   output logic             dis_o,
   output logic             susp_ack_o
);
   generate
      if (RES_W < 2 || RES_W > 16) begin : g_bad_width
         $error("frac_clk_div: RES_W must lie in 2..16");
      end
   endgenerate

   fd_mode_e mode;
   logic     advance;
   logic     load;

   fdiv_ctrl u_ctrl (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .mode_wr_i  (mode_wr_i),
      .mode_i     (mode_i),
      .dis_wr_i   (dis_wr_i),
      .dis_val_i  (dis_val_i),
      .hw_en_i    (hw_en_i),
      .ext_en_i   (ext_en_i),
      .susp_req_i (susp_req_i),
      .mode_o     (mode),
      .advance_o  (advance),
      .load_o     (load),
      .dis_o      (dis_o),
      .ack_o      (susp_ack_o)
   );

   fdiv_core #(.RES_W(RES_W), .REG_OUT(REG_OUT)) u_core (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mode_i    (mode),
      .advance_i (advance),
      .load_i    (load),
      .step_i    (step_i),
      .result_o  (result_o),
      .en_o      (clk_en_o)
   );

   generate
      if (REG_OUT) begin : g_out_checks
         a_r6_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            dis_o |=> !clk_en_o);
         a_r10_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (susp_req_i && susp_ack_o) |=> !clk_en_o);
      end
   endgenerate
endmodule

// File: tb/frac_clk_div_bench.sv
`timescale 1ns/1ps
module frac_clk_div_bench;
   typedef struct packed {
      logic       en;
      logic [9:0] res;
      logic       ack;
      logic       dis;
      logic [3:0] tag;
      logic [3:0] dtag;
   } exp_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode_wr = 1'b0;
   logic [1:0] mode = 2'b00;
   logic [9:0] step = '0;
   logic       dis_wr = 1'b0;
   logic       dis_val = 1'b0;
   logic       hw_en = 1'b0;
   logic       ext_en = 1'b0;
   logic       susp_req = 1'b0;
   logic       clk_en;
   logic [9:0] result;
   logic       dis;
   logic       ack;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   frac_clk_div u_frac_clk_div (
      .clk_i(clk), .rst_ni(rst_n), .mode_wr_i(mode_wr), .mode_i(mode),
      .step_i(step), .dis_wr_i(dis_wr), .dis_val_i(dis_val), .hw_en_i(hw_en),
      .ext_en_i(ext_en), .susp_req_i(susp_req), .clk_en_o(clk_en),
      .result_o(result), .dis_o(dis), .susp_ack_o(ack)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h @%0t", tag, act, exp, $time);
      end
   endtask

   // Reference model, written from the requirements, advanced at each rising edge
   logic [1:0] m_mode = 2'b00;
   logic [9:0] m_res  = '0;
   logic       m_dis  = 1'b0;
   logic       m_ack  = 1'b0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_mode = 2'b00; m_res = '0; m_dis = 1'b0; m_ack = 1'b0;
      end else begin
         exp_t e;
         logic       run, sus, adv, en_n;
         logic [9:0] res_n;
         logic [10:0] s;
         run   = !m_dis && (m_mode == 2'b01 || m_mode == 2'b10);
         sus   = susp_req && m_ack;
         adv   = run && !sus && !mode_wr;
         en_n  = 1'b0;
         res_n = m_res;
         if (mode_wr)    e.tag = 4'd2;   // R2
         else if (m_dis) e.tag = 4'd6;   // R6
         else if (sus)   e.tag = 4'd10;  // R10
         else if (m_mode == 2'b01) e.tag = 4'd3;  // R3
         else if (m_mode == 2'b10) e.tag = 4'd4;  // R4
         else e.tag = 4'd5;              // R5
         if (adv) begin
            if (m_mode == 2'b01) begin
               if (m_res == 10'h3FF) begin en_n = 1'b1; res_n = step; end
               else res_n = m_res + 10'd1;
            end else begin
               s = {1'b0, m_res} + {1'b0, step};
               en_n = s[10]; res_n = s[9:0];
            end
         end
         if (mode_wr) begin
            m_mode = mode;
            if (mode == 2'b01 || mode == 2'b10) res_n = 10'h3FF;
         end
         m_ack = susp_req && (m_ack || run);
         e.dtag = (hw_en && ext_en) ? 4'd7 : 4'd8;  // R7 / R8
         if (hw_en && ext_en) m_dis = 1'b0;
         else if (dis_wr)     m_dis = dis_val;
         m_res = res_n;
         e.en = en_n; e.res = m_res; e.ack = m_ack; e.dis = m_dis;
         q.push_back(e);
      end
   end

   // Monitor: compare design outputs with queued expectations at falling edges
   always @(negedge clk) begin
      if (rst_n && q.size() > 0) begin
         exp_t e;
         string t;
         e = q.pop_front();
         t = $sformatf("R%0d", e.tag);
         chk(clk_en == e.en, {t, " clk_en"}, clk_en, e.en);
         chk(result == e.res, {t, " result"}, result, e.res);
         chk(ack == e.ack, "R9 susp_ack", ack, e.ack);
         chk(dis == e.dis, $sformatf("R%0d dis", e.dtag), dis, e.dis);
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_mode(input logic [1:0] m);
      mode = m; mode_wr = 1'b1;
      tick(1);
      mode_wr = 1'b0;
   endtask

   task automatic write_dis(input logic v);
      dis_val = v; dis_wr = 1'b1;
      tick(1);
      dis_wr = 1'b0;
   endtask

   task automatic count_pulses(input int cycles, input int exp, input string tag);
      int n = 0;
      for (int i = 0; i < cycles; i++) begin
         tick(1);
         if (clk_en) n++;
      end
      chk(n == exp, tag, n, exp);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=0x0 expected=0x1");
      finish_run();
   end

   initial begin
      logic [9:0] held;
      tick(3);
      // R1: reset values
      chk(result == 10'h000, "R1 result", result, 0);
      chk(clk_en == 1'b0, "R1 clk_en", clk_en, 0);
      chk(dis == 1'b0, "R1 dis", dis, 0);
      chk(ack == 1'b0, "R1 ack", ack, 0);
      rst_n = 1'b1;
      tick(2);

      // R3: integer mode, step 0x3FC gives period 4
      step = 10'h3FC;
      write_mode(2'b01);
      chk(result == 10'h3FF, "R2 preset", result, 10'h3FF);
      tick(10);
      count_pulses(40, 10, "R3 pulse count");

      // R3: step 0 gives period 1024
      step = 10'h000;
      tick(20);
      count_pulses(2048, 2, "R3 period 0x400");

      // R4: fractional mode
      step = 10'h100;
      write_mode(2'b10);
      tick(4);
      count_pulses(40, 10, "R4 quarter rate");
      step = 10'h3FF;
      tick(50);
      step = 10'h155;
      tick(300);

      // R5: stop codes hold result and give no pulses
      write_mode(2'b11);
      held = result;
      count_pulses(30, 0, "R5 mode 11 quiet");
      chk(result == held, "R5 result held", result, held);
      write_mode(2'b00);
      tick(10);

      // R6: disabled, mode write still presets
      write_mode(2'b01);
      step = 10'h3F0;
      tick(7);
      write_dis(1'b1);
      tick(1);
      held = result;
      count_pulses(40, 0, "R6 disabled quiet");
      chk(result == held, "R6 frozen", result, held);
      step = 10'h200;
      write_mode(2'b10);
      chk(result == 10'h3FF, "R2 preset while disabled", result, 10'h3FF);
      tick(5);

      // R8: pin ignored without hardware control
      ext_en = 1'b1;
      tick(5);
      chk(dis == 1'b1, "R8 pin ignored", dis, 1);
      // R7: pin clears with hardware control, beats a write of 1
      hw_en = 1'b1;
      tick(1);
      chk(dis == 1'b0, "R7 pin clears", dis, 0);
      write_dis(1'b1);
      chk(dis == 1'b0, "R7 clear beats write", dis, 0);
      ext_en = 1'b0;
      write_dis(1'b1);
      chk(dis == 1'b1, "R7 write after pin low", dis, 1);
      hw_en = 1'b0;
      write_dis(1'b0);
      tick(10);

      // R9 / R10: suspend while running
      susp_req = 1'b1;
      tick(1);
      chk(ack == 1'b1, "R9 ack after one clock", ack, 1);
      tick(1);
      held = result;
      count_pulses(20, 0, "R10 suspended quiet");
      chk(result == held, "R10 frozen", result, held);
      write_mode(2'b01);
      chk(result == 10'h3FF, "R2 preset while suspended", result, 10'h3FF);
      susp_req = 1'b0;
      tick(1);
      chk(ack == 1'b0, "R9 ack drops", ack, 0);
      tick(20);

      // R9: request while stopped gets no acknowledge
      write_mode(2'b00);
      susp_req = 1'b1;
      tick(5);
      chk(ack == 1'b0, "R9 no ack when stopped", ack, 0);
      susp_req = 1'b0;
      tick(5);

      finish_run();
   end
endmodule